// File: doc/BRIEF.md
# Four-Cell Configurable Logic Fabric with Chained Switch Boxes

The block is a row of four identical configurable logic cells. Every cell has a routing switch box of its own, and the boxes are chained: the east bus of one box drives the west bus of the box to its right. Each cell holds a 64-entry lookup table for its parallel output and another for its serial output. Each of those outputs can be taken straight from the table or from a flip-flop clocked by the logic clock.

A serial loader shifts in a single configuration word. It then copies that word into all four cells at once, so every cell carries the same genome. One routing select pin sets how all boxes move signals between neighbours. With an adder genome and adder routing, the row is a 4-bit ripple-carry adder. With a counter genome and counter routing, it is a 4-bit synchronous up-counter with enable.

Logic registers advance only after every cell has been configured. The ready output tells the user when the outputs are meaningful.

Top module: `emb_fabric`

## Requirements
- R1: While reset is held and after it is released, before any load, `fab_ready`, `par_out`, `sb_in` and `east_out` are all zero.
- R2: The loader shifts `cfg_din` LSB first on each `cfg_clk` rise with `cfg_en` high, 130 bits per word. Bits [63:0] hold the parallel-output table and bits [127:64] the serial-output table. Bit 128 is the parallel-output register select and bit 129 the serial-output register select. One `cfg_clk` rise after the last bit, the word is committed and `fab_ready` goes high.
- R3: Every cell receives the same committed word. A table is indexed by {operand 1, box-to-cell bits 3..0, operand 0}, with operand 0 as bit 0 of the index.
- R4: A `cfg_clk` rise with `cfg_en` high drives `fab_ready` low in the next cycle. While `fab_ready` is low, no cell register changes on `lclk`.
- R5: A select bit of 0 makes its output combinational from the table. A select bit of 1 makes the output come from a register loaded on the `lclk` rise.
- R6: With `route_sel`=0, each box passes west bit 0 to box-to-cell bit 0 and drives box-to-cell bits 3..1 with 0. Its east bus is {0, 0, cell serial output}.
- R7: With `route_sel`=1, each box gives the cell its own registered serial state on box-to-cell bit 0 and west bits 0..2 on bits 1..3. Its east bus is {west[1], west[0], cell serial output}.
- R8: With the adder genome and `route_sel`=0, `par_out` is the 4-bit sum of operand 0 (`par_in` bit 2k), operand 1 (bit 2k+1) and carry-in `west_in[0]`. `sb_in[k]` is the carry out of cell k, and `east_out` is {0, 0, final carry}. This holds for all 512 input combinations.
- R9: In adder mode, carry-in 1 with operand 1 = 0011 and operand 0 = 0000 gives `par_out`=0100 and `sb_in`=0011.
- R10: With the counter genome, `route_sel`=1 and `west_in`=111, `sb_in` (bit k from cell k, so cell 0 holds Q0) and `par_out` hold the count. Each ready `lclk` rise with enable (`par_in` bit 2k) high adds one, wrapping from 15 to 0.
- R11: `east_out[0]` always equals `sb_in[3]`. With `route_sel`=1, `east_out[1]`=`sb_in[2]` and `east_out[2]`=`sb_in[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Configuration clock |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| lclk | input | 1 | Logic clock for cell registers |
| route_sel | input | 1 | Box routing: 0 adder, 1 counter |
| par_in | input | 8 | Two operand bits per cell, cell k at [2k+1:2k] |
| west_in | input | 3 | West bus of the first box |
| par_out | output | 4 | Parallel output of each cell |
| sb_in | output | 4 | Serial output of each cell, as fed into its box |
| east_out | output | 3 | East bus of the last box |
| fab_ready | output | 1 | All cells configured |

## Verification
A corrupted table entry or a wrong select bit shows up at once in adder mode. The affected `par_out` or `sb_in` bit is wrong within the same cycle, and a carry fault also ripples into every higher cell. In counter mode, a bad state register or feedback path shows in `sb_in` one `lclk` after the faulty step, and the error persists in later counts. A ready flag that fails to drop lets the count move during a reload, which is visible on the very next edge.

// File: rtl/emb_pkg.sv
package emb_pkg;
  parameter int BUS_W = 3;
  localparam int SB_W   = BUS_W + 1;
  localparam int ADDR_W = SB_W + 2;
  localparam int LUT_N  = 1 << ADDR_W;
  localparam int GEN_W  = 2 * LUT_N + 2;

  typedef struct packed {
    logic             ser_seq;
    logic             par_seq;
    logic [LUT_N-1:0] ser_lut;
    logic [LUT_N-1:0] par_lut;
  } genome_t;
endpackage

// File: rtl/emb_rst_sync.sv
module emb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/emb_loader.sv
module emb_loader
  import emb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shift_en,
  input  logic    shift_bit,
  output genome_t word,
  output logic    commit
);
  localparam int CNT_W = $clog2(GEN_W);

  logic [GEN_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cm_q, cm_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    cm_d  = 1'b0;
    if (shift_en) begin
      sh_d = {shift_bit, sh_q[GEN_W-1:1]};
      if (cnt_q == CNT_W'(GEN_W - 1)) begin
        cnt_d = '0;
        cm_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cm_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      cm_q  <= cm_d;
    end
  end

  assign word   = genome_t'(sh_q);
  assign commit = cm_q;
endmodule

// File: rtl/emb_cell.sv
module emb_cell
  import emb_pkg::*;
(
  input  logic            cfg_clk,
  input  logic            cfg_rst_n,
  input  logic            shift_en,
  input  logic            commit,
  input  genome_t         word,
  input  logic            lclk,
  input  logic            lrst_n,
  input  logic            run,
  input  logic [SB_W-1:0] from_box,
  input  logic [1:0]      pin,
  output logic            par_o,
  output logic            ser_o,
  output logic            ser_state,
  output logic            cfg_ok
);
  genome_t           g_q, g_d;
  logic              ok_q, ok_d;
  logic [ADDR_W-1:0] addr;
  logic              f_par, f_ser;
  logic              pq_q, pq_d, sq_q, sq_d;

  always_comb begin
    g_d  = g_q;
    ok_d = ok_q;
    if (shift_en) begin
      ok_d = 1'b0;
    end else if (commit) begin
      g_d  = word;
      ok_d = 1'b1;
    end
  end

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      g_q  <= '0;
      ok_q <= 1'b0;
    end else begin
      g_q  <= g_d;
      ok_q <= ok_d;
    end
  end

  assign addr  = {pin[1], from_box, pin[0]};
  assign f_par = g_q.par_lut[addr];
  assign f_ser = g_q.ser_lut[addr];

  always_comb begin
    pq_d = pq_q;
    sq_d = sq_q;
    if (run) begin
      pq_d = f_par;
      sq_d = f_ser;
    end
  end

  always_ff @(posedge lclk or negedge lrst_n) begin
    if (!lrst_n) begin
      pq_q <= 1'b0;
      sq_q <= 1'b0;
    end else begin
      pq_q <= pq_d;
      sq_q <= sq_d;
    end
  end

  assign par_o     = g_q.par_seq ? pq_q : f_par;
  assign ser_o     = g_q.ser_seq ? sq_q : f_ser;
  assign ser_state = sq_q;
  assign cfg_ok    = ok_q;
endmodule

// File: rtl/emb_sbox.sv
module emb_sbox
  import emb_pkg::*;
(
  input  logic             route_ctr,
  input  logic [BUS_W-1:0] west,
  input  logic             cell_out,
  input  logic             cell_state,
  output logic [SB_W-1:0]  to_cell,
  output logic [BUS_W-1:0] east
);
  assign to_cell = route_ctr ? {west, cell_state}
                             : {{BUS_W{1'b0}}, west[0]};
  assign east    = route_ctr ? {west[BUS_W-2:0], cell_out}
                             : {{(BUS_W-1){1'b0}}, cell_out};
endmodule

// File: rtl/emb_fabric.sv
module emb_fabric
  import emb_pkg::*;
#(
  parameter int N_CELL = 4
) (
  input  logic                rst_n,
  input  logic                cfg_clk,
  input  logic                cfg_en,
  input  logic                cfg_din,
  input  logic                lclk,
  input  logic                route_sel,
  input  logic [2*N_CELL-1:0] par_in,
  input  logic [BUS_W-1:0]    west_in,
  output logic [N_CELL-1:0]   par_out,
  output logic [N_CELL-1:0]   sb_in,
  output logic [BUS_W-1:0]    east_out,
  output logic                fab_ready
);
  logic              cfg_rst_n, l_rst_n;
  genome_t           word;
  logic              commit;
  logic [N_CELL-1:0] cell_ok;
  logic [N_CELL-1:0] ser_state;

  emb_rst_sync #(.STAGES(2)) u_cfg_rst (
    .clk(cfg_clk), .rst_n(rst_n), .rst_n_sync(cfg_rst_n));
  emb_rst_sync #(.STAGES(2)) u_l_rst (
    .clk(lclk), .rst_n(rst_n), .rst_n_sync(l_rst_n));

  emb_loader u_loader (
    .clk(cfg_clk), .rst_n(cfg_rst_n), .shift_en(cfg_en),
    .shift_bit(cfg_din), .word(word), .commit(commit));

  assign fab_ready = &cell_ok;

  for (genvar i = 0; i < N_CELL; i++) begin : g_cell
    logic [BUS_W-1:0] west_w, east_w;
    logic [SB_W-1:0]  box_w;
    logic             par_w, ser_w, st_w;

    if (i == 0) begin : g_edge
      assign west_w = west_in;
    end else begin : g_link
      assign west_w = g_cell[i-1].east_w;
    end

    emb_cell u_cell (
      .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .shift_en(cfg_en),
      .commit(commit), .word(word), .lclk(lclk), .lrst_n(l_rst_n),
      .run(fab_ready), .from_box(box_w), .pin(par_in[2*i +: 2]),
      .par_o(par_w), .ser_o(ser_w), .ser_state(st_w), .cfg_ok(cell_ok[i]));

    emb_sbox u_box (
      .route_ctr(route_sel), .west(west_w), .cell_out(ser_w),
      .cell_state(st_w), .to_cell(box_w), .east(east_w));

    assign par_out[i]   = par_w;
    assign sb_in[i]     = ser_w;
    assign ser_state[i] = st_w;
  end

  assign east_out = g_cell[N_CELL-1].east_w;
endmodule

// File: rtl/emb_fabric_chk.sv
module emb_fabric_chk
  import emb_pkg::*;
#(
  parameter int N_CELL = 4
) (
  input logic              lclk,
  input logic              cfg_clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              route_sel,
  input logic [N_CELL-1:0] sb_in,
  input logic [BUS_W-1:0]  east_out,
  input logic              fab_ready,
  input logic [N_CELL-1:0] state
);
  // R4
  ready_drop_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_en |=> !fab_ready);

  // R4
  state_hold_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    !fab_ready |=> $stable(state));

  // R6
  add_east_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    !route_sel |-> (east_out[BUS_W-1:1] == '0));

  // R7
  ctr_pass_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    route_sel |-> (east_out[2] == sb_in[N_CELL-3] && east_out[1] == sb_in[N_CELL-2]));

  // R11
  last_east_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    east_out[0] == sb_in[N_CELL-1]);
endmodule

bind emb_fabric emb_fabric_chk #(.N_CELL(N_CELL)) u_chk (
  .lclk(lclk), .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en),
  .route_sel(route_sel), .sb_in(sb_in), .east_out(east_out),
  .fab_ready(fab_ready), .state(ser_state));

// File: tb/test_emb_fabric.sv
`timescale 1ns/1ps
module test_emb_fabric;
  import emb_pkg::*;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n, cfg_en, cfg_din, route_sel;
  logic [2*NC-1:0] par_in;
  logic [BUS_W-1:0] west_in;
  logic [NC-1:0] par_out, sb_in;
  logic [BUS_W-1:0] east_out;
  logic          fab_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int unsigned m;

  always #2.5 clk = ~clk;

  emb_fabric i_emb_fabric (
    .rst_n(rst_n), .cfg_clk(clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lclk(clk), .route_sel(route_sel), .par_in(par_in), .west_in(west_in),
    .par_out(par_out), .sb_in(sb_in), .east_out(east_out), .fab_ready(fab_ready));

  function automatic genome_t adder_word();
    genome_t g = '0;
    for (int a = 0; a < LUT_N; a++) begin
      logic x = a[0], y = a[5], c = a[1];
      g.par_lut[a] = x ^ y ^ c;
      g.ser_lut[a] = (x & y) | (x & c) | (y & c);
    end
    return g;
  endfunction

  function automatic genome_t counter_word();
    genome_t g = '0;
    for (int a = 0; a < LUT_N; a++) begin
      logic nx = a[1] ^ (a[2] & a[3] & a[4] & a[0]);
      g.par_lut[a] = nx;
      g.ser_lut[a] = nx;
    end
    g.par_seq = 1'b1;
    g.ser_seq = 1'b1;
    return g;
  endfunction

  function automatic logic [2*NC-1:0] spread(logic [NC-1:0] op0, logic [NC-1:0] op1);
    logic [2*NC-1:0] v;
    for (int k = 0; k < NC; k++) begin
      v[2*k]   = op0[k];
      v[2*k+1] = op1[k];
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(genome_t g);
    logic [GEN_W-1:0] bits = g;
    for (int i = 0; i < GEN_W; i++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = bits[i];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_din = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic add_vec(logic [NC-1:0] a, logic [NC-1:0] b, logic cin);
    logic [NC:0]   s;
    logic [NC-1:0] cy;
    logic          c;
    par_in  = spread(a, b);
    west_in = {2'b00, cin};
    #1;
    s = a + b + cin;
    c = cin;
    for (int k = 0; k < NC; k++) begin
      cy[k] = (a[k] & b[k]) | (a[k] & c) | (b[k] & c);
      c = cy[k];
    end
    chk(par_out == s[NC-1:0], "R8 R3 R5 sum", par_out, s[NC-1:0]);
    chk(sb_in == cy, "R8 R6 carries", sb_in, cy);
    chk(east_out == {2'b00, s[NC]}, "R8 R6 R11 east", east_out, {2'b00, s[NC]});
  endtask

  task automatic ctr_check(string req);
    logic [NC-1:0] q = m[NC-1:0];
    chk(sb_in == q, req, sb_in, q);
    chk(par_out == q, req, par_out, q);
    chk(east_out == {q[1], q[2], q[3]}, "R11 R7 east", east_out, {q[1], q[2], q[3]});
  endtask

  task automatic ctr_tick(logic en);
    par_in = spread({NC{en}}, '0);
    @(posedge clk);
    if (en) m = (m + 1) % 16;
    @(negedge clk);
    ctr_check("R10 R5 count");
  endtask

  initial begin
    int unsigned rs;
    genome_t cw;
    logic [GEN_W-1:0] cbits;
    rs = $urandom(32'd7);
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; route_sel = 1'b0;
    par_in = '0; west_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fab_ready == 1'b0, "R1 ready", fab_ready, 0);
    chk(par_out == '0, "R1 par_out", par_out, 0);
    chk(sb_in == '0, "R1 sb_in", sb_in, 0);
    chk(east_out == '0, "R1 east", east_out, 0);

    // adder configuration
    load(adder_word());
    chk(fab_ready == 1'b1, "R2 ready after load", fab_ready, 1);
    add_vec(4'b0000, 4'b0011, 1'b1);
    chk(par_out == 4'b0100, "R9 sum", par_out, 4'b0100);
    chk(sb_in == 4'b0011, "R9 carries", sb_in, 4'b0011);
    for (int v = 0; v < 512; v++) add_vec(v[3:0], v[7:4], v[8]);

    // counter configuration
    do_reset();
    route_sel = 1'b1;
    west_in   = 3'b111;
    par_in    = '0;
    m = 0;
    cw = counter_word();
    load(cw);
    chk(fab_ready == 1'b1, "R2 ready after counter load", fab_ready, 1);
    ctr_check("R10 start");
    for (int t = 0; t < 20; t++) ctr_tick(1'b1);
    for (int t = 0; t < 20; t++) ctr_tick(1'($urandom % 2));

    // R4 reload: count frozen while not ready
    cbits = cw;
    par_in = spread({NC{1'b1}}, '0);
    cfg_en = 1'b1; cfg_din = cbits[0];
    @(posedge clk);
    m = (m + 1) % 16;
    for (int i = 1; i < GEN_W; i++) begin
      @(negedge clk);
      chk(fab_ready == 1'b0, "R4 ready low", fab_ready, 0);
      chk(sb_in == m[NC-1:0], "R4 hold", sb_in, m[NC-1:0]);
      cfg_din = cbits[i];
    end
    @(negedge clk);
    cfg_en = 1'b0; cfg_din = 1'b0;
    chk(sb_in == m[NC-1:0], "R4 hold last", sb_in, m[NC-1:0]);
    @(negedge clk);
    chk(fab_ready == 1'b1, "R2 R4 ready back", fab_ready, 1);
    chk(sb_in == m[NC-1:0], "R4 no step on commit", sb_in, m[NC-1:0]);
    ctr_tick(1'b1);
    ctr_tick(1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule